// File: doc/BRIEF.md
# Multi-Cycle Fetch-Execute Sequencer

This block is the control unit of a small 32-bit load/store processor whose datapath moves data one register transfer per clock. It walks each instruction through fetch, decode, operand read, execute, result write and next-instruction setup. It raises the one-cycle strobes that load the memory address register from the program counter, capture memory data, move that data into the instruction register, write the register file, and either advance or reload the program counter. The register file, memory, ALU and program counter sit outside the block.

The sequencer sees the upper twenty bits of the instruction register, which carry the opcode and three register fields, and a branch-taken flag from the datapath. It returns the register-file port addresses, an ALU operation select and the transfer strobes. Instructions that need no operands or no result skip those steps. Register-to-register ALU operations take eight cycles, branches take six and unrecognised opcodes take five.

Top module: `fetch_sequencer`

## Requirements
- R1: While `rst` is high the block holds its first fetch state. In the first cycle after release only `maLoadPc` is high among the strobes and `regWrite` is low.
- R2: Every instruction begins with three consecutive cycles in which `maLoadPc`, then `mdLoadMem`, then `irLoadMd` is high.
- R3: The cycle after `irLoadMd` is a decode cycle with every strobe low. In it the opcode is taken from `irFields[19:15]` (IR bits 31:27). From the next cycle on, `xAddr` carries IR bits 26:22 (ra), `aAddr` carries bits 21:17 (rb) and `bAddr` carries bits 16:12 (rc).
- R4: Opcode to `aluSel` mapping: 1 add→0 (A+B), 2 subtract→1 (A−B), 3 and→2, 4 or→3, 5 negate→4 (−B), 6 complement→5 (~B). The select stays stable while the result is written.
- R5: An ALU instruction takes 8 cycles. `regWrite` is high for exactly one cycle, the 7th, which gives one rising edge per instruction. A write is always followed by a setup cycle with `pcInc`.
- R6: No more than one of `maLoadPc`, `mdLoadMem`, `irLoadMd`, `regWrite`, `pcInc`, `pcLoad` is high in any cycle.
- R7: The last cycle of every instruction is a setup cycle. For opcode 8 (branch) with `brTaken` high it raises `pcLoad`, and the PC is reloaded from the port-A register. Otherwise it raises `pcInc`, and the datapath adds 4. A branch takes 6 cycles and never writes a register.
- R8: An unrecognised opcode (any value other than 1–6 and 8) takes 5 cycles, issues no register write and ends with `pcInc`.
- R9: The cycle after a setup cycle starts the next fetch with `maLoadPc`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irFields | input | 20 | IR bits 31:12: opcode, ra, rb, rc |
| brTaken | input | 1 | Branch condition met, computed by the datapath |
| maLoadPc | output | 1 | Load memory address register from PC |
| mdLoadMem | output | 1 | Load memory data register from memory at MA |
| irLoadMd | output | 1 | Load instruction register from MD |
| aAddr | output | 5 | Register-file read port A address |
| bAddr | output | 5 | Register-file read port B address |
| xAddr | output | 5 | Register-file write port address |
| regWrite | output | 1 | Write strobe; the write happens on its rising edge |
| aluSel | output | 3 | ALU operation select |
| pcInc | output | 1 | Advance PC by 4 |
| pcLoad | output | 1 | Load PC from branch target |

## Verification
The bound checker watches the local ordering rules on every cycle:
- the fetch triplet,
- the quiet decode cycle,
- the single-cycle write pulse,
- the single strobe per cycle,
- the stable ALU select during a write,
- the new fetch after each setup.

The whole-instruction properties can only be shown by the bench's scenarios, because they depend on a datapath model. These are the per-class cycle counts, the correct ALU results landing in the right register, branches taken and not taken under several conditions, the skipped instruction after a taken branch, an unrecognised opcode leaving the registers alone, and a reset in mid-instruction.

// File: rtl/seq_pkg.sv
package seq_pkg;

  typedef enum logic [2:0] {
    ST_FETCH_MA,
    ST_FETCH_MD,
    ST_FETCH_IR,
    ST_DECODE,
    ST_OPREAD,
    ST_EXEC,
    ST_WRITE,
    ST_NEXT
  } seqState_t;

  typedef enum logic [1:0] {
    KIND_ALU    = 2'd0,
    KIND_BRANCH = 2'd1,
    KIND_NONE   = 2'd2
  } opKind_t;

  localparam int ALU_SEL_W = 3;
  typedef logic [ALU_SEL_W-1:0] aluSel_t;

  localparam aluSel_t ALU_ADD = 3'd0;
  localparam aluSel_t ALU_SUB = 3'd1;
  localparam aluSel_t ALU_AND = 3'd2;
  localparam aluSel_t ALU_OR  = 3'd3;
  localparam aluSel_t ALU_NEG = 3'd4;
  localparam aluSel_t ALU_NOT = 3'd5;

  localparam int OPC_ADD = 1;
  localparam int OPC_SUB = 2;
  localparam int OPC_AND = 3;
  localparam int OPC_OR  = 4;
  localparam int OPC_NEG = 5;
  localparam int OPC_NOT = 6;
  localparam int OPC_BR  = 8;

  // Strobes from control to the field/decode datapath and out to the machine
  typedef struct packed {
    logic maLoadPc;
    logic mdLoadMem;
    logic irLoadMd;
    logic latchFields;
    logic regWrite;
    logic pcInc;
    logic pcLoad;
  } ctrlStrobe_t;

endpackage

// File: rtl/seq_datapath.sv
module seq_datapath
  import seq_pkg::*;
#(
  parameter int OP_W   = 5,
  parameter int REG_AW = 5
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [OP_W+3*REG_AW-1:0]   irFields,
  input  ctrlStrobe_t                strobe,
  output opKind_t                    opKind,
  output logic [REG_AW-1:0]          aAddr,
  output logic [REG_AW-1:0]          bAddr,
  output logic [REG_AW-1:0]          xAddr,
  output aluSel_t                    aluSel
);

  localparam int FIELD_W = OP_W + 3 * REG_AW;
  localparam int NUM_REG_FIELDS = 3;

  logic [OP_W-1:0] opField;
  logic [REG_AW-1:0] regField [NUM_REG_FIELDS];
  logic [REG_AW-1:0] regFieldQ [NUM_REG_FIELDS];
  aluSel_t aluNext;

  assign opField = irFields[FIELD_W-1 -: OP_W];

  // Index 2 = ra (dest), 1 = rb (port A), 0 = rc (port B)
  for (genvar g = 0; g < NUM_REG_FIELDS; g++) begin : gField
    assign regField[g] = irFields[(g+1)*REG_AW-1 -: REG_AW];
    always_ff @(posedge clk) begin
      if (rst) regFieldQ[g] <= '0;
      else if (strobe.latchFields) regFieldQ[g] <= regField[g];
    end
  end

  always_comb begin
    opKind  = KIND_NONE;
    aluNext = ALU_ADD;
    case (opField)
      OP_W'(OPC_ADD): begin opKind = KIND_ALU; aluNext = ALU_ADD; end
      OP_W'(OPC_SUB): begin opKind = KIND_ALU; aluNext = ALU_SUB; end
      OP_W'(OPC_AND): begin opKind = KIND_ALU; aluNext = ALU_AND; end
      OP_W'(OPC_OR):  begin opKind = KIND_ALU; aluNext = ALU_OR;  end
      OP_W'(OPC_NEG): begin opKind = KIND_ALU; aluNext = ALU_NEG; end
      OP_W'(OPC_NOT): begin opKind = KIND_ALU; aluNext = ALU_NOT; end
      OP_W'(OPC_BR):  begin opKind = KIND_BRANCH; end
      default:        begin opKind = KIND_NONE; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) aluSel <= ALU_ADD;
    else if (strobe.latchFields) aluSel <= aluNext;
  end

  assign xAddr = regFieldQ[2];
  assign aAddr = regFieldQ[1];
  assign bAddr = regFieldQ[0];

endmodule

// File: rtl/seq_control.sv
module seq_control
  import seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  opKind_t     opKind,
  input  logic        brTaken,
  output ctrlStrobe_t strobe
);

  seqState_t state, stateNext;
  opKind_t kindQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_FETCH_MA;
      kindQ <= KIND_NONE;
    end else begin
      state <= stateNext;
      if (state == ST_DECODE) kindQ <= opKind;
    end
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_FETCH_MA: stateNext = ST_FETCH_MD;
      ST_FETCH_MD: stateNext = ST_FETCH_IR;
      ST_FETCH_IR: stateNext = ST_DECODE;
      ST_DECODE:   stateNext = (opKind == KIND_NONE) ? ST_NEXT : ST_OPREAD;
      ST_OPREAD:   stateNext = (kindQ == KIND_BRANCH) ? ST_NEXT : ST_EXEC;
      ST_EXEC:     stateNext = ST_WRITE;
      ST_WRITE:    stateNext = ST_NEXT;
      ST_NEXT:     stateNext = ST_FETCH_MA;
      default:     stateNext = ST_FETCH_MA;
    endcase
  end

  always_comb begin
    strobe = '0;
    case (state)
      ST_FETCH_MA: strobe.maLoadPc    = 1'b1;
      ST_FETCH_MD: strobe.mdLoadMem   = 1'b1;
      ST_FETCH_IR: strobe.irLoadMd    = 1'b1;
      ST_DECODE:   strobe.latchFields = 1'b1;
      ST_WRITE:    strobe.regWrite    = 1'b1;
      ST_NEXT: begin
        strobe.pcLoad = (kindQ == KIND_BRANCH) && brTaken;
        strobe.pcInc  = !((kindQ == KIND_BRANCH) && brTaken);
      end
      default: strobe = '0;
    endcase
  end

endmodule

// File: rtl/fetch_sequencer.sv
module fetch_sequencer
  import seq_pkg::*;
#(
  parameter int OP_W   = 5,
  parameter int REG_AW = 5
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [OP_W+3*REG_AW-1:0] irFields,
  input  logic                     brTaken,
  output logic                     maLoadPc,
  output logic                     mdLoadMem,
  output logic                     irLoadMd,
  output logic [REG_AW-1:0]        aAddr,
  output logic [REG_AW-1:0]        bAddr,
  output logic [REG_AW-1:0]        xAddr,
  output logic                     regWrite,
  output logic [ALU_SEL_W-1:0]     aluSel,
  output logic                     pcInc,
  output logic                     pcLoad
);

  ctrlStrobe_t strobe;
  opKind_t opKind;

  seq_control u_ctrl (
    .clk(clk), .rst(rst), .opKind(opKind), .brTaken(brTaken), .strobe(strobe)
  );

  seq_datapath #(.OP_W(OP_W), .REG_AW(REG_AW)) u_dp (
    .clk(clk), .rst(rst), .irFields(irFields), .strobe(strobe),
    .opKind(opKind), .aAddr(aAddr), .bAddr(bAddr), .xAddr(xAddr), .aluSel(aluSel)
  );

  assign maLoadPc  = strobe.maLoadPc;
  assign mdLoadMem = strobe.mdLoadMem;
  assign irLoadMd  = strobe.irLoadMd;
  assign regWrite  = strobe.regWrite;
  assign pcInc     = strobe.pcInc;
  assign pcLoad    = strobe.pcLoad;

endmodule

// File: rtl/fetch_sequencer_chk.sv
module fetch_sequencer_chk #(
  parameter int SEL_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             maLoadPc,
  input logic             mdLoadMem,
  input logic             irLoadMd,
  input logic             regWrite,
  input logic [SEL_W-1:0] aluSel,
  input logic             pcInc,
  input logic             pcLoad
);

  // R2
  fetch_md_follows_chk: assert property (@(posedge clk) disable iff (rst)
    maLoadPc |=> mdLoadMem);

  // R2
  fetch_ir_follows_chk: assert property (@(posedge clk) disable iff (rst)
    mdLoadMem |=> irLoadMd);

  // R3
  decode_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    irLoadMd |=> !(maLoadPc || mdLoadMem || irLoadMd || regWrite || pcInc || pcLoad));

  // R6
  single_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({maLoadPc, mdLoadMem, irLoadMd, regWrite, pcInc, pcLoad}));

  // R5
  write_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    regWrite |=> !regWrite);

  // R5
  write_then_inc_chk: assert property (@(posedge clk) disable iff (rst)
    regWrite |=> pcInc);

  // R4
  sel_stable_chk: assert property (@(posedge clk) disable iff (rst)
    regWrite |-> $stable(aluSel));

  // R9
  setup_then_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    (pcInc || pcLoad) |=> maLoadPc);

endmodule

bind fetch_sequencer fetch_sequencer_chk #(.SEL_W(seq_pkg::ALU_SEL_W)) u_chk (
  .clk(clk), .rst(rst), .maLoadPc(maLoadPc), .mdLoadMem(mdLoadMem),
  .irLoadMd(irLoadMd), .regWrite(regWrite), .aluSel(aluSel),
  .pcInc(pcInc), .pcLoad(pcLoad)
);

// File: tb/fetch_sequencer_bench.sv
`timescale 1ns/1ps
module fetch_sequencer_bench;

  logic clk = 1'b0;
  logic rst = 1'b0;
  always #10 clk = ~clk;

  logic [31:0] ir = '0, md = '0, ma = '0, pc = '0;
  logic [31:0] mem [32];
  logic [31:0] regs [32];
  logic brTaken;
  logic maLoadPc, mdLoadMem, irLoadMd, regWrite, pcInc, pcLoad;
  logic [4:0] aAddr, bAddr, xAddr;
  logic [2:0] aluSel;

  int checks = 0;
  int fails = 0;
  int wEdges = 0;
  bit finished = 0;

  fetch_sequencer u_fetch_sequencer (
    .clk(clk), .rst(rst), .irFields(ir[31:12]), .brTaken(brTaken),
    .maLoadPc(maLoadPc), .mdLoadMem(mdLoadMem), .irLoadMd(irLoadMd),
    .aAddr(aAddr), .bAddr(bAddr), .xAddr(xAddr), .regWrite(regWrite),
    .aluSel(aluSel), .pcInc(pcInc), .pcLoad(pcLoad)
  );

  // Datapath model
  always @(posedge clk) begin
    if (rst) pc <= '0;
    else begin
      if (maLoadPc) ma <= pc;
      if (mdLoadMem) md <= mem[ma[6:2]];
      if (irLoadMd) ir <= md;
      if (pcInc) pc <= pc + 32'd4;
      else if (pcLoad) pc <= regs[aAddr];
    end
  end

  function automatic logic [31:0] aluFn(input logic [2:0] s, input logic [31:0] a, input logic [31:0] b);
    case (s)
      3'd0: return a + b;
      3'd1: return a - b;
      3'd2: return a & b;
      3'd3: return a | b;
      3'd4: return -b;
      3'd5: return ~b;
      default: return 32'hDEAD_BEEF;
    endcase
  endfunction

  always @(posedge regWrite or posedge rst) begin
    if (rst) begin
      for (int i = 0; i < 32; i++) regs[i] <= '0;
      regs[1] <= 32'd7;
      regs[2] <= 32'd3;
      regs[10] <= 32'd40;
    end else begin
      regs[xAddr] <= aluFn(aluSel, regs[aAddr], regs[bAddr]);
      wEdges <= wEdges + 1;
    end
  end

  always_comb begin
    case (ir[2:0])
      3'd0: brTaken = 1'b0;
      3'd1: brTaken = 1'b1;
      3'd2: brTaken = (regs[bAddr] == 0);
      3'd3: brTaken = (regs[bAddr] != 0);
      3'd4: brTaken = !regs[bAddr][31] && (regs[bAddr] != 0);
      3'd5: brTaken = regs[bAddr][31];
      default: brTaken = 1'b0;
    endcase
  end

  function automatic logic [31:0] mk(input int op, input int ra, input int rb, input int rc, input int cond);
    return {op[4:0], ra[4:0], rb[4:0], rc[4:0], 9'd0, cond[2:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Runs one instruction from its maLoadPc cycle to the next one.
  task automatic stepOne(input string name, input int expCycles, input int expEdges, input bit expLoad, input string req);
    int n = 0;
    int e0 = wEdges;
    bit lastInc = 0, lastLoad = 0;
    chk(maLoadPc == 1'b1, "R9", {name, " start fetch"}, maLoadPc, 1);
    do begin
      lastInc = pcInc; lastLoad = pcLoad;
      @(negedge clk); n++;
      if (n == 1) chk(mdLoadMem == 1'b1, "R2", {name, " md load"}, mdLoadMem, 1);
      if (n == 2) chk(irLoadMd == 1'b1, "R2", {name, " ir load"}, irLoadMd, 1);
      if (n == 3) chk({maLoadPc, mdLoadMem, irLoadMd, regWrite, pcInc, pcLoad} == 6'b0,
                      "R3", {name, " decode quiet"},
                      {maLoadPc, mdLoadMem, irLoadMd, regWrite, pcInc, pcLoad}, 0);
    end while (!maLoadPc && n < 20);
    chk(n == expCycles, req, {name, " cycles"}, n, expCycles);
    chk((wEdges - e0) == expEdges, req, {name, " write edges"}, wEdges - e0, expEdges);
    chk(lastLoad == expLoad && lastInc == !expLoad, "R7", {name, " setup strobe"},
        {lastLoad, lastInc}, {expLoad, !expLoad});
  endtask

  task automatic testReset();
    chk(maLoadPc == 1'b1 && {mdLoadMem, irLoadMd, regWrite, pcInc, pcLoad} == 5'b0,
        "R1", "first cycle after reset", {maLoadPc, mdLoadMem, irLoadMd, regWrite, pcInc, pcLoad}, 6'b100000);
    chk(pc == 0, "R1", "pc at reset", pc, 0);
  endtask

  task automatic testAlu();
    stepOne("add", 8, 1, 0, "R5");
    chk(regs[3] == 32'd10, "R4", "add r3", regs[3], 10);
    chk(pc == 4, "R7", "pc after add", pc, 4);
    stepOne("sub", 8, 1, 0, "R5");
    chk(regs[4] == 32'd4, "R4", "sub r4", regs[4], 4);
    stepOne("and", 8, 1, 0, "R5");
    chk(regs[5] == 32'd3, "R4", "and r5", regs[5], 3);
    stepOne("or", 8, 1, 0, "R5");
    chk(regs[6] == 32'd7, "R4", "or r6", regs[6], 7);
    stepOne("neg", 8, 1, 0, "R5");
    chk(regs[7] == 32'hFFFF_FFFD, "R4", "neg r7", regs[7], 32'hFFFF_FFFD);
    stepOne("not", 8, 1, 0, "R5");
    chk(regs[8] == 32'hFFFF_FFF8, "R4", "not r8", regs[8], 32'hFFFF_FFF8);
    chk(pc == 24, "R7", "pc after alu group", pc, 24);
  endtask

  task automatic testUnknown();
    stepOne("unknown", 5, 0, 0, "R8");
    chk(regs[9] == 0, "R8", "r9 untouched", regs[9], 0);
    chk(pc == 28, "R8", "pc after unknown", pc, 28);
  endtask

  task automatic testBranch();
    stepOne("br never", 6, 0, 0, "R7");
    chk(pc == 32, "R7", "pc after br never", pc, 32);
    stepOne("br zero", 6, 0, 1, "R7");
    chk(pc == 40, "R7", "pc after taken br", pc, 40);
    stepOne("br plus", 6, 0, 0, "R7");
    chk(pc == 44, "R7", "pc after untaken br", pc, 44);
    chk(regs[11] == 0, "R7", "skipped instr left r11", regs[11], 0);
    stepOne("add self", 8, 1, 0, "R5");
    chk(regs[3] == 32'd20, "R3", "dest equals sources", regs[3], 20);
  endtask

  task automatic testMidReset();
    repeat (3) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    testReset();
    stepOne("add after reset", 8, 1, 0, "R1");
    chk(regs[3] == 32'd10, "R1", "r3 after restart", regs[3], 10);
    chk(regs[12] == 0, "R1", "interrupted write absent", regs[12], 0);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) mem[i] = mk(0, 0, 0, 0, 0);
    mem[0]  = mk(1, 3, 1, 2, 0);
    mem[1]  = mk(2, 4, 1, 2, 0);
    mem[2]  = mk(3, 5, 1, 2, 0);
    mem[3]  = mk(4, 6, 1, 2, 0);
    mem[4]  = mk(5, 7, 0, 2, 0);
    mem[5]  = mk(6, 8, 0, 1, 0);
    mem[6]  = mk(0, 9, 1, 2, 0);
    mem[7]  = mk(8, 0, 10, 1, 0);
    mem[8]  = mk(8, 0, 10, 0, 2);
    mem[9]  = mk(1, 11, 1, 2, 0);
    mem[10] = mk(8, 0, 10, 7, 4);
    mem[11] = mk(1, 3, 3, 3, 0);
    mem[12] = mk(1, 12, 1, 2, 0);
    #1 rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    testReset();
    testAlu();
    testUnknown();
    testBranch();
    testMidReset();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule